// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block saves and restores processor state for a small 8-bit CPU when it takes or leaves an interrupt. It watches an active-low, level-sensitive request line that several open-drain sources share, and the mask bit of the condition code register. When a request is pending, the mask is clear and the CPU signals an instruction boundary, the block writes the register file to a descending memory stack, one byte per cycle. It then sets the mask bit, reads a two-byte handler address from a fixed location and loads it into the program counter.

On a return command the block reads the saved frame back in the reverse order and reloads every register. The condition code register comes back first, so the mask returns to the value it had before entry. The CPU holds its register outputs steady while `busy` is high and applies every one-hot load the block issues. Clearing the mask inside a handler lets a request that is still low start a nested entry. That entry stacks below the first frame.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_we`, `mem_re`, `sp_ld` and `ld_sel` are all low.
- R2: An entry starts only on a clock edge where `insn_done` is high, `irq_n` is low and bit 4 (the mask bit) of `ccr_in` is clear. A low `irq_n` without a boundary, or with the mask set, has no effect.
- R3: Entry writes nine bytes on consecutive cycles to addresses SP, SP-1, …, SP-8. The bytes are PC low, PC high, X low, X high, Y low, Y high, A, B, CCR, where SP is `sp_in` at the accepting edge.
- R4: After the last write, the block loads CCR (`ld_sel` bit 5) with `ccr_in` plus bit 4 set and all other bits unchanged. `ld_sel` bits are 0 PC, 1 X, 2 Y, 3 A, 4 B, 5 CCR, and 8-bit registers use `ld_data[7:0]`.
- R5: The block then reads the high byte at 16'hFFF2 and the low byte at 16'hFFF3 and loads them into PC. In the same cycle it raises `done` for one cycle and writes SP-9 through `sp_ld`/`sp_out`. `done` arrives 13 cycles after the accepting edge.
- R6: A return command at a boundary reads SP+1 to SP+9 and loads CCR, B, A, Y, X, PC in that order, each 16-bit register high byte first. It raises `done` 10 cycles after the accepting edge and writes SP+9 to the stack pointer.
- R7: While a sequence runs, boundary strobes, request changes and return commands are ignored. The running sequence keeps its timing and frame.
- R8: If the mask is cleared during a handler while the request is still low, the next boundary starts a nested entry whose frame lies directly below the first. Two returns then restore the original state.
- R9: When a return command and an acceptable request arrive at the same boundary, the return is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Shared active-low request line |
| insn_done | input | 1 | Instruction boundary strobe |
| rti_cmd | input | 1 | Return-from-interrupt command |
| pc_in | input | 16 | Current program counter |
| x_in | input | 16 | Current X index |
| y_in | input | 16 | Current Y index |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition code register |
| sp_in | input | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe, data one cycle later |
| mem_rdata | input | 8 | Memory read data |
| ld_sel | output | 6 | One-hot register load select |
| ld_data | output | 16 | Register load data |
| sp_ld | output | 1 | Stack pointer load strobe |
| sp_out | output | 16 | New stack pointer value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that successive stack writes step down by one address and pops step up by one. They also check that a read and a write never coincide, that register loads stay one-hot, that `done` is a single-cycle pulse and that a masked or unstrobed request never makes the block busy. Only the bench scenarios can show the actual byte order of a frame, the mask bit in the loaded CCR, the handler address and the exact latencies. The same goes for full restoration after a return, nested frames and return priority, because these depend on memory contents and on the CPU model looping loads back into the inputs.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_MASK,
        ST_VHI,
        ST_VLO,
        ST_VFIN,
        ST_POP
    } seq_state_e;

    typedef enum logic [2:0] {
        RID_PC  = 3'd0,
        RID_X   = 3'd1,
        RID_Y   = 3'd2,
        RID_A   = 3'd3,
        RID_B   = 3'd4,
        RID_CCR = 3'd5
    } reg_id_e;

    localparam int NUM_REGS    = 6;
    localparam int FRAME_BYTES = 9;
endpackage

// File: rtl/irq_frame_map.sv
module irq_frame_map
    import irq_seq_pkg::*;
(
    input  logic [3:0] idx,
    output reg_id_e    reg_id,
    output logic       hi_byte
);
    // frame slot 0 is the first byte written (at the original SP)
    always_comb begin
        hi_byte = idx[0] && (idx < 4'd6);
        case (idx)
            4'd0, 4'd1: reg_id = RID_PC;
            4'd2, 4'd3: reg_id = RID_X;
            4'd4, 4'd5: reg_id = RID_Y;
            4'd6:       reg_id = RID_A;
            4'd7:       reg_id = RID_B;
            default:    reg_id = RID_CCR;
        endcase
    end
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
    parameter int DW    = 8,
    parameter int I_BIT = 4
) (
    input  logic          idle,
    input  logic          insn_done,
    input  logic          irq_n,
    input  logic          rti_cmd,
    input  logic [DW-1:0] ccr_in,
    output logic          take_irq,
    output logic          take_rti
);
    always_comb begin
        take_rti = idle && insn_done && rti_cmd;
        take_irq = idle && insn_done && !irq_n && !ccr_in[I_BIT] && !rti_cmd;
    end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_seq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter int            I_BIT    = 4,
    parameter logic [AW-1:0] VEC_ADDR = 16'hFFF2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_n,
    input  logic                insn_done,
    input  logic                rti_cmd,
    input  logic [2*DW-1:0]     pc_in,
    input  logic [2*DW-1:0]     x_in,
    input  logic [2*DW-1:0]     y_in,
    input  logic [DW-1:0]       a_in,
    input  logic [DW-1:0]       b_in,
    input  logic [DW-1:0]       ccr_in,
    input  logic [AW-1:0]       sp_in,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_we,
    output logic [DW-1:0]       mem_wdata,
    output logic                mem_re,
    input  logic [DW-1:0]       mem_rdata,
    output logic [NUM_REGS-1:0] ld_sel,
    output logic [2*DW-1:0]     ld_data,
    output logic                sp_ld,
    output logic [AW-1:0]       sp_out,
    output logic                busy,
    output logic                done
);
    localparam logic [3:0]    LAST_IDX  = 4'(FRAME_BYTES - 1);
    localparam logic [AW-1:0] FRAME_LEN = AW'(FRAME_BYTES);
    localparam logic [DW-1:0] MASK_SET  = DW'(1) << I_BIT;

    typedef struct packed {
        seq_state_e    st;
        logic [3:0]    step;
        logic [AW-1:0] sp;
        logic [DW-1:0] hold;
    } seq_t;

    seq_t    seq_d, seq_q;
    logic    take_irq, take_rti;
    reg_id_e push_id, pop_id;
    logic    push_hi, pop_hi;
    logic [DW-1:0] push_byte;
    logic [3:0]    pop_idx;

    assign busy    = (seq_q.st != ST_IDLE);
    assign pop_idx = 4'(FRAME_BYTES) - seq_q.step;

    irq_req_gate #(.DW(DW), .I_BIT(I_BIT)) u_gate (
        .idle      (!busy),
        .insn_done (insn_done),
        .irq_n     (irq_n),
        .rti_cmd   (rti_cmd),
        .ccr_in    (ccr_in),
        .take_irq  (take_irq),
        .take_rti  (take_rti)
    );

    irq_frame_map u_push_map (.idx(seq_q.step), .reg_id(push_id), .hi_byte(push_hi));
    irq_frame_map u_pop_map  (.idx(pop_idx),    .reg_id(pop_id),  .hi_byte(pop_hi));

    always_comb begin
        case (push_id)
            RID_PC:  push_byte = push_hi ? pc_in[2*DW-1:DW] : pc_in[DW-1:0];
            RID_X:   push_byte = push_hi ? x_in[2*DW-1:DW]  : x_in[DW-1:0];
            RID_Y:   push_byte = push_hi ? y_in[2*DW-1:DW]  : y_in[DW-1:0];
            RID_A:   push_byte = a_in;
            RID_B:   push_byte = b_in;
            default: push_byte = ccr_in;
        endcase
    end

    always_comb begin
        seq_d     = seq_q;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        mem_re    = 1'b0;
        ld_sel    = '0;
        ld_data   = '0;
        sp_ld     = 1'b0;
        sp_out    = seq_q.sp;
        done      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                seq_d.step = '0;
                seq_d.sp   = sp_in;
                if (take_rti)      seq_d.st = ST_POP;
                else if (take_irq) seq_d.st = ST_PUSH;
            end
            ST_PUSH: begin
                mem_we    = 1'b1;
                mem_addr  = seq_q.sp - AW'(seq_q.step);
                mem_wdata = push_byte;
                if (seq_q.step == LAST_IDX) begin
                    seq_d.st   = ST_MASK;
                    seq_d.step = '0;
                end else begin
                    seq_d.step = seq_q.step + 4'd1;
                end
            end
            ST_MASK: begin
                ld_sel[RID_CCR] = 1'b1;
                ld_data         = {{DW{1'b0}}, ccr_in | MASK_SET};
                seq_d.st        = ST_VHI;
            end
            ST_VHI: begin
                mem_re   = 1'b1;
                mem_addr = VEC_ADDR;
                seq_d.st = ST_VLO;
            end
            ST_VLO: begin
                mem_re     = 1'b1;
                mem_addr   = VEC_ADDR + AW'(1);
                seq_d.hold = mem_rdata;
                seq_d.st   = ST_VFIN;
            end
            ST_VFIN: begin
                ld_sel[RID_PC] = 1'b1;
                ld_data        = {seq_q.hold, mem_rdata};
                done           = 1'b1;
                sp_ld          = 1'b1;
                sp_out         = seq_q.sp - FRAME_LEN;
                seq_d.st       = ST_IDLE;
            end
            ST_POP: begin
                if (seq_q.step <= LAST_IDX) begin
                    mem_re   = 1'b1;
                    mem_addr = seq_q.sp + AW'(seq_q.step) + AW'(1);
                end
                if (seq_q.step != 4'd0) begin
                    if (pop_hi) begin
                        seq_d.hold = mem_rdata;
                    end else begin
                        ld_sel[pop_id] = 1'b1;
                        ld_data = (pop_id inside {RID_PC, RID_X, RID_Y}) ?
                                  {seq_q.hold, mem_rdata} : {{DW{1'b0}}, mem_rdata};
                    end
                end
                if (seq_q.step == 4'(FRAME_BYTES)) begin
                    done     = 1'b1;
                    sp_ld    = 1'b1;
                    sp_out   = seq_q.sp + FRAME_LEN;
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.step = seq_q.step + 4'd1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, step: '0, sp: '0, hold: '0};
        else        seq_q <= seq_d;
    end

    assert_push_descends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

    assert_pop_ascends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_POP && mem_re && $past(mem_re) && $past(seq_q.st == ST_POP))
        |-> (mem_addr == $past(mem_addr) + AW'(1)));

    assert_port_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_load_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_sel));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_masked_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rti_cmd && (ccr_in[I_BIT] || irq_n || !insn_done)) |=> !busy);
endmodule

// File: tb/irq_stack_seq_bench.sv
module irq_stack_seq_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] pc;
        logic [15:0] x;
        logic [15:0] y;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [7:0]  ccr;
        logic [15:0] sp;
        logic [15:0] vec;
    } scen_t;

    localparam scen_t SCEN [4] = '{
        '{pc:16'h1234, x:16'hABCD, y:16'h5678, a:8'h11, b:8'h22, ccr:8'h00, sp:16'h0080, vec:16'hC000},
        '{pc:16'hFFFE, x:16'h0001, y:16'h8000, a:8'hFF, b:8'h00, ccr:8'hC5, sp:16'h0070, vec:16'h0102},
        '{pc:16'h0000, x:16'h7F7F, y:16'h0F0F, a:8'h5A, b:8'hA5, ccr:8'h2B, sp:16'h00A0, vec:16'hE5E5},
        '{pc:16'h4321, x:16'hFEDC, y:16'h0000, a:8'h80, b:8'h7F, ccr:8'h0F, sp:16'h0060, vec:16'h9ABC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1;
    logic        insn_done = 1'b0;
    logic        rti_cmd = 1'b0;
    logic [15:0] pc_r = '0, x_r = '0, y_r = '0, sp_r = '0;
    logic [7:0]  a_r = '0, b_r = '0, ccr_r = '0;
    logic [15:0] mem_addr, ld_data, sp_out;
    logic        mem_we, mem_re, sp_ld, busy, done;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [5:0]  ld_sel;
    logic [7:0]  mem [256];

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_stack_seq u_irq_stack_seq (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .insn_done(insn_done), .rti_cmd(rti_cmd),
        .pc_in(pc_r), .x_in(x_r), .y_in(y_r), .a_in(a_r), .b_in(b_r), .ccr_in(ccr_r),
        .sp_in(sp_r), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .ld_sel(ld_sel), .ld_data(ld_data),
        .sp_ld(sp_ld), .sp_out(sp_out), .busy(busy), .done(done)
    );

    // synchronous memory: data one cycle after the read strobe
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    // CPU register model applies loads mid-cycle
    always @(negedge clk) begin
        if (ld_sel[0]) pc_r  = ld_data;
        if (ld_sel[1]) x_r   = ld_data;
        if (ld_sel[2]) y_r   = ld_data;
        if (ld_sel[3]) a_r   = ld_data[7:0];
        if (ld_sel[4]) b_r   = ld_data[7:0];
        if (ld_sel[5]) ccr_r = ld_data[7:0];
        if (sp_ld)     sp_r  = sp_out;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                insn_done = 1'b0;
                rti_cmd   = 1'b0;
            end
        end while (!done && n < 40);
        @(negedge clk);
    endtask

    task automatic load_regs(input scen_t s);
        pc_r = s.pc; x_r = s.x; y_r = s.y; a_r = s.a; b_r = s.b; ccr_r = s.ccr; sp_r = s.sp;
        mem[8'hF2] = s.vec[15:8];
        mem[8'hF3] = s.vec[7:0];
    endtask

    task automatic check_frame(input string tag, input scen_t s, input logic [15:0] base);
        logic [7:0] exp [9];
        exp = '{s.pc[7:0], s.pc[15:8], s.x[7:0], s.x[15:8], s.y[7:0], s.y[15:8], s.a, s.b, s.ccr};
        for (int k = 0; k < 9; k++) begin
            logic [15:0] ad;
            ad = base - 16'(k);
            chk(tag, {24'h0, mem[ad[7:0]]}, {24'h0, exp[k]});
        end
    endtask

    task automatic check_regs(input string tag, input scen_t s);
        chk(tag, {16'h0, pc_r}, {16'h0, s.pc});
        chk(tag, {16'h0, x_r},  {16'h0, s.x});
        chk(tag, {16'h0, y_r},  {16'h0, s.y});
        chk(tag, {16'h0, a_r, b_r}, {16'h0, s.a, s.b});
        chk(tag, {24'h0, ccr_r}, {24'h0, s.ccr});
        chk(tag, {16'h0, sp_r},  {16'h0, s.sp});
    endtask

    task automatic do_entry(output int n);
        @(negedge clk);
        irq_n = 1'b0;
        insn_done = 1'b1;
        wait_done(n);
    endtask

    task automatic do_return(output int n);
        @(negedge clk);
        rti_cmd = 1'b1;
        insn_done = 1'b1;
        wait_done(n);
    endtask

    initial begin
        int n;
        scen_t s;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy/done", {30'h0, busy, done}, 32'h0);
        chk("R1 mem strobes", {30'h0, mem_we, mem_re}, 32'h0);
        chk("R1 loads", {25'h0, sp_ld, ld_sel}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of scenarios: entry then return
        for (int i = 0; i < 4; i++) begin
            s = SCEN[i];
            load_regs(s);
            do_entry(n);
            chk("R5 entry latency", n, 13);
            irq_n = 1'b1;
            check_frame("R3 frame byte", s, s.sp);
            chk("R4 ccr mask set", {24'h0, ccr_r}, {24'h0, s.ccr | 8'h10});
            chk("R5 pc from vector", {16'h0, pc_r}, {16'h0, s.vec});
            chk("R5 sp after entry", {16'h0, sp_r}, {16'h0, s.sp - 16'd9});
            x_r = ~s.x; y_r = ~s.y; a_r = ~s.a; b_r = ~s.b; pc_r = 16'h5555;
            do_return(n);
            chk("R6 return latency", n, 10);
            check_regs("R6 restored", s);
        end

        // R2: request without boundary, and masked request at boundary
        s = SCEN[0];
        load_regs(s);
        irq_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 no boundary", {31'h0, busy}, 32'h0);
        ccr_r = 8'h10;
        insn_done = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 masked", {31'h0, busy}, 32'h0);
        chk("R2 pc untouched", {16'h0, pc_r}, {16'h0, s.pc});
        insn_done = 1'b0;
        irq_n = 1'b1;
        ccr_r = s.ccr;

        // R7: strobes and return command mid-sequence are ignored
        s = SCEN[1];
        load_regs(s);
        @(negedge clk);
        irq_n = 1'b0;
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        n = 1;
        repeat (3) begin @(negedge clk); n++; end
        insn_done = 1'b1;
        rti_cmd = 1'b1;
        @(negedge clk); n++;
        insn_done = 1'b0;
        rti_cmd = 1'b0;
        while (!done && n < 40) begin @(negedge clk); n++; end
        @(negedge clk);
        chk("R7 latency kept", n, 13);
        check_frame("R7 frame kept", s, s.sp);
        chk("R7 sp", {16'h0, sp_r}, {16'h0, s.sp - 16'd9});
        irq_n = 1'b1;
        do_return(n);
        check_regs("R7 restored", s);

        // R8: nested entry after handler clears the mask
        s = SCEN[2];
        load_regs(s);
        do_entry(n);
        ccr_r = ccr_r & 8'hEF;
        do_entry(n);
        chk("R8 nested latency", n, 13);
        irq_n = 1'b1;
        chk("R8 nested sp", {16'h0, sp_r}, {16'h0, s.sp - 16'd18});
        chk("R8 nested pc word", {16'h0, mem[8'(s.sp - 16'd10)], mem[8'(s.sp - 16'd9)]},
            {16'h0, s.vec});
        chk("R8 nested ccr byte", {24'h0, mem[8'(s.sp - 16'd17)]}, {24'h0, s.ccr});
        check_frame("R8 outer frame", s, s.sp);
        do_return(n);
        chk("R8 inner return pc", {16'h0, pc_r}, {16'h0, s.vec});
        do_return(n);
        check_regs("R8 outer restored", s);

        // R9: return wins over a simultaneous request
        s = SCEN[3];
        load_regs(s);
        mem[8'(s.sp + 16'd1)] = 8'h01;
        mem[8'(s.sp + 16'd2)] = 8'h22;
        mem[8'(s.sp + 16'd3)] = 8'h33;
        mem[8'(s.sp + 16'd4)] = 8'h44;
        mem[8'(s.sp + 16'd5)] = 8'h55;
        mem[8'(s.sp + 16'd6)] = 8'h66;
        mem[8'(s.sp + 16'd7)] = 8'h77;
        mem[8'(s.sp + 16'd8)] = 8'h12;
        mem[8'(s.sp + 16'd9)] = 8'h34;
        @(negedge clk);
        irq_n = 1'b0;
        do_return(n);
        irq_n = 1'b1;
        chk("R9 return latency", n, 10);
        check_regs("R9 popped", '{pc:16'h1234, x:16'h6677, y:16'h4455, a:8'h33, b:8'h22,
                                   ccr:8'h01, sp:s.sp + 16'd9, vec:16'h0});

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule